// File: doc/BRIEF.md
# Serial Two-Register Configuration Port

This block is a write-mostly serial port that loads one of two 18-bit configuration words from a three-wire link: a serial clock, an active-low frame strobe and a data line. While the strobe is low, every rising edge of the serial clock pushes one bit into a 19-bit shift register. When the strobe returns high, the newest 19 bits are taken as a frame. The last bit of the frame selects the target word and the 18 bits before it become the new word. Any extra bits clocked in ahead of these are simply pushed out.

The serial pins are brought into a faster system clock through multi-stage synchronizers, and their edges are detected in that clock domain. The oldest shift-register bit is driven on a serial output, which changes only after a falling serial clock edge. Several ports can therefore share one strobe in a daisy chain, or a controller can read back the frame it sent before. A lock input turns writes to the control word into no-ops and leaves the data word writable. A supply-good input clears every register while it is low. A one-cycle update pulse marks each word that is actually written, so that downstream timers can reload.

Top module: `sercfg_port`

## Requirements
- R1: A frame is 19 bits. The 18 payload bits come first, most significant first, and the select bit comes last. Bit k of the written word is the payload bit sent in position 17-k.
- R2: A bit is shifted in only on a rising serial clock edge seen while the strobe is low. Serial clock edges while the strobe is high leave the shift register unchanged.
- R3: On a rising strobe edge, the 19 most recently shifted bits are committed, however many bits were clocked in before them.
- R4: A select bit of 0 writes `data_word` and a select bit of 1 writes `ctrl_word`. The word that is not selected keeps its value.
- R5: While `ctrl_lock` is high, a frame with select bit 1 is dropped and `ctrl_word` keeps its value. Frames with select bit 0 are still written.
- R6: `ser_dout` delivers the shift-register contents oldest bit first. Sampled just before each rising serial clock edge, it reproduces the 19 bits shifted in 19 edges earlier.
- R7: `ser_dout` changes only in response to a falling serial clock edge. It holds its value across a rising edge.
- R8: While `supply_ok` is low, both words, the shift register and `ser_dout` are zero. A strobe that follows with no bits shifted therefore commits an all-zero data frame.
- R9: Each committed write raises the update pulse of its own word for exactly one system clock cycle. A dropped write raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| supply_ok | input | 1 | Logic-supply-good; low clears all state (asynchronous) |
| ser_clk | input | 1 | Serial clock; shifts on rising edge |
| ser_strobe_n | input | 1 | Frame strobe, active low; rising edge commits |
| ser_din | input | 1 | Serial data in |
| ctrl_lock | input | 1 | High blocks writes to the control word |
| ser_dout | output | 1 | Serial data out for chaining and readback |
| data_word | output | 18 | Data register image |
| ctrl_word | output | 18 | Control register image |
| data_upd | output | 1 | One-cycle pulse when data_word is written |
| ctrl_upd | output | 1 | One-cycle pulse when ctrl_word is written |

## Verification
The bench builds the port with its default 18-bit payload and two synchronizer stages. With those values, a walking-one sweep over all 18 data bit positions can be run, along with full-width control patterns. They also keep the complete 19-bit chain-out sequence short enough to compare bit by bit against the frame that was sent. Half-bit periods of four system cycles put each synchronized edge well clear of the next one. As a result, the bench can use fixed sampling points for strobe-high clocking, overlong frames, locked writes and a supply drop in the middle of a frame.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

    typedef enum logic {
        SEL_DATA = 1'b0,
        SEL_CTRL = 1'b1
    } word_sel_e;

    localparam int IDX_SCK  = 0;
    localparam int IDX_STR  = 1;
    localparam int IDX_SDI  = 2;
    localparam int IDX_LOCK = 3;
    localparam int N_SYNC   = 4;

endpackage

// File: rtl/sercfg_sync.sv
module sercfg_sync #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    // pipe_q[0..STAGES-1] synchronize, pipe_q[STAGES] holds previous level
    logic [STAGES:0][W-1:0] pipe_d, pipe_q;
    logic [W-1:0]           prev;

    always_comb begin
        pipe_d    = pipe_q;
        pipe_d[0] = async_in;
        for (int i = 1; i <= STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {(STAGES+1){RST_VAL}};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign lvl  = pipe_q[STAGES-1];
    assign prev = pipe_q[STAGES];
    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;

endmodule

// File: rtl/sercfg_shifter.sv
module sercfg_shifter #(
    parameter int FRAME_W = 19
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_tick,
    input  logic               out_tick,
    input  logic               hold,
    input  logic               din,
    output logic [FRAME_W-1:0] frame,
    output logic               dout
);
    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic               dout;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_tick && !hold) begin
            st_d.sr = {st_q.sr[FRAME_W-2:0], din};
        end
        if (out_tick) begin
            st_d.dout = st_q.sr[FRAME_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame = st_q.sr;
    assign dout  = st_q.dout;

    // R2: strobe high freezes the shift register
    p_hold_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(st_q.sr));

    // R7: serial output moves only after a falling serial clock edge
    p_dout_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_tick |=> $stable(st_q.dout));

endmodule

// File: rtl/sercfg_commit.sv
module sercfg_commit
    import sercfg_pkg::*;
#(
    parameter int PAYLOAD_W = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 commit,
    input  logic                 lock,
    input  logic [PAYLOAD_W:0]   frame,
    output logic [PAYLOAD_W-1:0] data_word,
    output logic [PAYLOAD_W-1:0] ctrl_word,
    output logic                 data_upd,
    output logic                 ctrl_upd
);
    typedef struct packed {
        logic [PAYLOAD_W-1:0] data;
        logic [PAYLOAD_W-1:0] ctrl;
        logic                 dupd;
        logic                 cupd;
    } commit_st_t;

    commit_st_t st_d, st_q;
    word_sel_e  sel;

    assign sel = word_sel_e'(frame[0]);

    always_comb begin
        st_d      = st_q;
        st_d.dupd = 1'b0;
        st_d.cupd = 1'b0;
        if (commit) begin
            if (sel == SEL_DATA) begin
                st_d.data = frame[PAYLOAD_W:1];
                st_d.dupd = 1'b1;
            end else if (!lock) begin
                st_d.ctrl = frame[PAYLOAD_W:1];
                st_d.cupd = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_word = st_q.data;
    assign ctrl_word = st_q.ctrl;
    assign data_upd  = st_q.dupd;
    assign ctrl_upd  = st_q.cupd;

    // R4: data word changes only together with its update pulse
    p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.dupd |-> $stable(st_q.data));

    // R5: control word changes only together with its update pulse
    p_ctrl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.cupd |-> $stable(st_q.ctrl));

    // R5: locked control frame produces no control update
    p_lock_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && frame[0] && lock) |=> !st_q.cupd);

    // R9: update pulses last a single cycle
    p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dupd || st_q.cupd) |=> !(st_q.dupd || st_q.cupd));

endmodule

// File: rtl/sercfg_port.sv
module sercfg_port
    import sercfg_pkg::*;
#(
    parameter int PAYLOAD_W   = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 supply_ok,
    input  logic                 ser_clk,
    input  logic                 ser_strobe_n,
    input  logic                 ser_din,
    input  logic                 ctrl_lock,
    output logic                 ser_dout,
    output logic [PAYLOAD_W-1:0] data_word,
    output logic [PAYLOAD_W-1:0] ctrl_word,
    output logic                 data_upd,
    output logic                 ctrl_upd
);
    localparam int FRAME_W = PAYLOAD_W + 1;
    // idle levels: serial clock and strobe high, so release from reset makes no edge
    localparam logic [N_SYNC-1:0] SYNC_IDLE =
        (N_SYNC'(1) << IDX_SCK) | (N_SYNC'(1) << IDX_STR);

    logic [N_SYNC-1:0]  raw, lvl, rise, fall;
    logic [FRAME_W-1:0] frame;

    assign raw[IDX_SCK]  = ser_clk;
    assign raw[IDX_STR]  = ser_strobe_n;
    assign raw[IDX_SDI]  = ser_din;
    assign raw[IDX_LOCK] = ctrl_lock;

    sercfg_sync #(
        .W       (N_SYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_IDLE)
    ) u_sync (
        .clk      (clk),
        .rst_n    (supply_ok),
        .async_in (raw),
        .lvl      (lvl),
        .rise     (rise),
        .fall     (fall)
    );

    sercfg_shifter #(
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (supply_ok),
        .shift_tick (rise[IDX_SCK]),
        .out_tick   (fall[IDX_SCK]),
        .hold       (lvl[IDX_STR]),
        .din        (lvl[IDX_SDI]),
        .frame      (frame),
        .dout       (ser_dout)
    );

    sercfg_commit #(
        .PAYLOAD_W (PAYLOAD_W)
    ) u_commit (
        .clk       (clk),
        .rst_n     (supply_ok),
        .commit    (rise[IDX_STR]),
        .lock      (lvl[IDX_LOCK]),
        .frame     (frame),
        .data_word (data_word),
        .ctrl_word (ctrl_word),
        .data_upd  (data_upd),
        .ctrl_upd  (ctrl_upd)
    );

    // R9: the two update pulses never coincide
    p_upd_exclusive_r9: assert property (@(posedge clk) disable iff (!supply_ok)
        $onehot0({data_upd, ctrl_upd}));

endmodule

// File: tb/sercfg_port_tb.sv
module sercfg_port_tb;
    localparam int PW = 18;
    localparam int FW = PW + 1;

    logic          clk = 1'b0;
    logic          supply_ok, sck, str_n, sdi, lock;
    logic          ser_dout, data_upd, ctrl_upd;
    logic [PW-1:0] data_word, ctrl_word;

    int checks = 0;
    int fails  = 0;
    int dupd_n = 0;
    int cupd_n = 0;

    always #10 clk = ~clk;

    sercfg_port u_dut (
        .clk          (clk),
        .supply_ok    (supply_ok),
        .ser_clk      (sck),
        .ser_strobe_n (str_n),
        .ser_din      (sdi),
        .ctrl_lock    (lock),
        .ser_dout     (ser_dout),
        .data_word    (data_word),
        .ctrl_word    (ctrl_word),
        .data_upd     (data_upd),
        .ctrl_upd     (ctrl_upd)
    );

    always @(posedge clk) begin
        if (data_upd) dupd_n++;
        if (ctrl_upd) cupd_n++;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        sck = 1'b0; sdi = b; wclk(4);
        sck = 1'b1; wclk(4);
    endtask

    task automatic frame_out(input logic [PW-1:0] p, input logic sel);
        str_n = 1'b0; wclk(4);
        for (int i = PW - 1; i >= 0; i--) bit_out(p[i]);
        bit_out(sel);
        str_n = 1'b1; wclk(8);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired (all R) actual=%0h expected=%0h", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [PW-1:0] last_data, last_ctrl, pat;
        logic [FW-1:0] got, sent;
        int d0, c0;
        logic [PW-1:0] ctrl_pats [4];
        ctrl_pats[0] = 18'h2AAAA; ctrl_pats[1] = 18'h15555;
        ctrl_pats[2] = 18'h3FFFF; ctrl_pats[3] = 18'h00001;

        supply_ok = 1'b0; sck = 1'b1; str_n = 1'b1; sdi = 1'b0; lock = 1'b0;
        wclk(5);
        supply_ok = 1'b1;
        wclk(8);
        // R8 reset state
        chk(data_word == '0, "R8 data after reset", data_word, 0);
        chk(ctrl_word == '0, "R8 ctrl after reset", ctrl_word, 0);
        chk(ser_dout == 1'b0, "R8 dout after reset", ser_dout, 0);

        // R1 / R4 / R9 walking one over every data bit position
        for (int k = 0; k < PW; k++) begin
            d0 = dupd_n; c0 = cupd_n;
            pat = PW'(1) << k;
            frame_out(pat, 1'b0);
            chk(data_word == pat, "R1 data walking bit", data_word, pat);
            chk(ctrl_word == '0, "R4 ctrl untouched by data frame", ctrl_word, 0);
            chk(dupd_n == d0 + 1 && cupd_n == c0, "R9 single data pulse", dupd_n - d0, 1);
        end
        last_data = PW'(1) << (PW - 1);

        // R4 control writes
        for (int k = 0; k < 4; k++) begin
            d0 = dupd_n; c0 = cupd_n;
            frame_out(ctrl_pats[k], 1'b1);
            chk(ctrl_word == ctrl_pats[k], "R4 ctrl write", ctrl_word, ctrl_pats[k]);
            chk(data_word == last_data, "R4 data untouched by ctrl frame", data_word, last_data);
            chk(cupd_n == c0 + 1 && dupd_n == d0, "R9 single ctrl pulse", cupd_n - c0, 1);
        end
        last_ctrl = ctrl_pats[3];

        // R5 lock drops control, keeps data
        lock = 1'b1; wclk(8);
        c0 = cupd_n;
        frame_out(18'h0F0F0, 1'b1);
        chk(ctrl_word == last_ctrl, "R5 locked ctrl unchanged", ctrl_word, last_ctrl);
        chk(cupd_n == c0, "R9 no pulse on dropped write", cupd_n - c0, 0);
        frame_out(18'h12345, 1'b0);
        chk(data_word == 18'h12345, "R5 data writable while locked", data_word, 18'h12345);
        lock = 1'b0; wclk(8);

        // R3 overlong frame: only the last 19 bits count
        str_n = 1'b0; wclk(4);
        for (int i = 0; i < 25; i++) bit_out(logic'(i % 3 == 0));
        pat = 18'h2C3A5;
        for (int i = PW - 1; i >= 0; i--) bit_out(pat[i]);
        bit_out(1'b0);
        str_n = 1'b1; wclk(8);
        chk(data_word == pat, "R3 last 19 bits committed", data_word, pat);
        chk(ctrl_word == last_ctrl, "R3 ctrl untouched", ctrl_word, last_ctrl);

        // R2 clocking while strobe high shifts nothing
        for (int i = 0; i < 6; i++) bit_out(1'b1);
        d0 = dupd_n;
        str_n = 1'b0; wclk(6);
        str_n = 1'b1; wclk(8);
        chk(data_word == pat, "R2 no shift while strobe high", data_word, pat);
        chk(dupd_n == d0 + 1, "R2 recommit pulse", dupd_n - d0, 1);

        // R6 / R7 chain-out of the previous frame
        frame_out(18'h1B6D3, 1'b0);
        sent = {18'h1B6D3, 1'b0};
        pat  = 18'h0A5C3;
        got  = '0;
        str_n = 1'b0; wclk(4);
        for (int i = FW - 1; i >= 0; i--) begin
            logic cap;
            sck = 1'b0; sdi = (i == 0) ? 1'b0 : pat[i-1]; wclk(4);
            cap = ser_dout;
            got[i] = cap;
            sck = 1'b1; wclk(3);
            chk(ser_dout == cap, "R7 dout holds across rising edge", ser_dout, cap);
            wclk(1);
        end
        str_n = 1'b1; wclk(8);
        chk(got == sent, "R6 chained output equals previous frame", got, sent);
        chk(data_word == pat, "R6 new frame committed", data_word, pat);

        // R8 supply drop mid-frame clears the shift register and words
        frame_out(18'h3C3C3, 1'b1);
        str_n = 1'b0; wclk(4);
        for (int i = 0; i < 5; i++) bit_out(1'b1);
        supply_ok = 1'b0; wclk(4);
        chk(data_word == '0, "R8 data cleared", data_word, 0);
        chk(ctrl_word == '0, "R8 ctrl cleared", ctrl_word, 0);
        chk(ser_dout == 1'b0, "R8 dout cleared", ser_dout, 0);
        supply_ok = 1'b1; wclk(8);
        d0 = dupd_n; c0 = cupd_n;
        str_n = 1'b1; wclk(8);
        chk(data_word == '0 && ctrl_word == '0, "R8 zero frame committed", {data_word, ctrl_word}, 0);
        chk(dupd_n == d0 + 1 && cupd_n == c0, "R8 zero frame targets data", cupd_n - c0, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule